// File: doc/BRIEF.md
# Caption Text Row Dot Renderer

This block draws one row of caption text as a stream of coloured dots. Each row is 33 cells of 8 dots. Cell 0 holds the row's starting attribute byte. Cells 1 to 32 hold either a character code or an in-line control code. While a cell is on screen, the block reads that cell's byte from an external display memory and looks up the glyph line in an external font table. It then applies the current colour, italics, underline and flash settings and emits one dot per dot-clock cycle on R, G, B and an overlay-enable line.

The dot clock is assumed to be locked to the video timing. The surrounding logic supplies three things: a one-cycle `line_start` pulse where the text area begins on a video line, the row to draw (`row_sel`), and the scanline within the character cell (`scan_row`). It also pulses `vsync` once per video field. That pulse advances the frame counter used for flashing. Both memories are read combinationally: the data must be valid in the same cycle as the address.

Top module: `cc_caption_row`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `r`, `g`, `b` and `bl` are all 0.
- R2: When `line_start` is sampled high at a clock edge, the row scan begins. Dot n of the row (n = 0..263, cell = n/8, dot in cell = n mod 8) appears on the outputs after the (n+1)-th following edge. Once the row has ended, and whenever no row is being scanned, all outputs are 0. `mem_addr` is `{row_sel, cell}`, with the cell number in the low 6 bits.
- R3: Cell 0 is drawn blank. Its byte seeds the attributes for the cells that follow: bits [2:0] colour, bit 3 italics, bit 4 underline, bit 5 flash.
- R4: A character cell (byte bit 7 = 0) shows glyph-line bit 7 first and bit 0 last. A dot that is on drives `r`, `g` and `b` from colour bits 2, 1 and 0, and `bl` is 1 exactly for the dots that are on.
- R5: A control cell (byte bit 7 = 1) is drawn blank. Its bits [5:0], in the R3 layout, replace the attributes from the next cell onward.
- R6: With italics set, on scanlines 0..3 the glyph line is shifted right by one dot: the first dot is off and dot k shows glyph bit 8-k.
- R7: With underline set, every dot of a character cell is on at scanline 7.
- R8: The frame counter is 5 bits. It resets to 0 and steps on each `vsync` pulse. While its top bit is 0, the dots of character cells with flash set are all off, underline included.
- R9: Whenever `bl` is 0, `r`, `g` and `b` are 0.
- R10: A `line_start` during a scan restarts the row from cell 0.
- R11: For a character cell, `font_idx` equals the byte's bits [6:0] and `font_line` equals `scan_row`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | One-cycle pulse per video field |
| line_start | input | 1 | One-cycle pulse that starts a row scan |
| row_sel | input | 4 | Text row to draw |
| scan_row | input | 3 | Scanline within the character cell |
| mem_addr | output | 10 | Display memory address {row, cell} |
| mem_data | input | 8 | Display memory byte at `mem_addr` |
| font_idx | output | 7 | Glyph index into the font table |
| font_line | output | 3 | Glyph scanline into the font table |
| font_bits | input | 8 | Glyph line, bit 7 leftmost |
| r | output | 1 | Red dot |
| g | output | 1 | Green dot |
| b | output | 1 | Blue dot |
| bl | output | 1 | Overlay enable for the dot |

## Verification
The hardest state to reach is a flashing cell while the flash phase is high. The counter only reaches that phase after sixteen field pulses, so the stimulus scans rows first with the phase low, then issues sixteen `vsync` pulses and scans the same rows again, and later wraps the counter back to low. A second hard case is a restart that lands in the middle of a row while the attributes have already been changed by control cells. The stimulus fires `line_start` partway through such a row and expects the seed byte to take over again.

// File: rtl/cc_caption_pkg.sv
package cc_caption_pkg;
  localparam int CELL_W = 8;
  localparam int DOT_W  = 3;
  localparam int GIDX_W = 7;

  typedef struct packed {
    logic       flash;
    logic       uline;
    logic       italic;
    logic [2:0] color;
  } cc_attr_t;

  function automatic cc_attr_t attr_of(input logic [CELL_W-1:0] b);
    return cc_attr_t'(b[5:0]);
  endfunction

  function automatic logic is_ctrl(input logic [CELL_W-1:0] b);
    return b[CELL_W-1];
  endfunction

  function automatic logic [CELL_W-1:0] slant(input logic [CELL_W-1:0] bits, input logic en);
    return en ? {1'b0, bits[CELL_W-1:1]} : bits;
  endfunction

  // dot 0 is the leftmost, i.e. glyph bit 7
  function automatic logic pick_dot(input logic [CELL_W-1:0] bits, input logic [DOT_W-1:0] idx);
    return bits[~idx];
  endfunction
endpackage

// File: rtl/cc_cell_timer.sv
module cc_cell_timer #(
  parameter int COLS  = 32,
  parameter int COL_W = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              line_start,
  output logic                              busy,
  output logic [COL_W-1:0]                  col,
  output logic [cc_caption_pkg::DOT_W-1:0]  dot,
  output logic                              cell_end,
  output logic                              row_last
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS);

  assign cell_end = busy && (&dot);
  assign row_last = cell_end && (col == LAST_COL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      col  <= '0;
      dot  <= '0;
    end else if (line_start) begin
      busy <= 1'b1;
      col  <= '0;
      dot  <= '0;
    end else if (busy) begin
      dot <= dot + 1'b1;
      if (row_last) begin
        busy <= 1'b0;
        col  <= '0;
      end else if (cell_end) begin
        col <= col + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cc_attr_state.sv
module cc_attr_state (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                load,
  input  logic [cc_caption_pkg::CELL_W-1:0]   code,
  output cc_caption_pkg::cc_attr_t            attr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    attr <= '0;
    else if (load) attr <= cc_caption_pkg::attr_of(code);
  end
endmodule

// File: rtl/cc_flash_timer.sv
module cc_flash_timer #(
  parameter int FLASH_LOG = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vsync,
  output logic [FLASH_LOG-1:0] frame_cnt,
  output logic                 phase
);
  always_ff @(posedge clk) begin
    if (!rst_n)     frame_cnt <= '0;
    else if (vsync) frame_cnt <= frame_cnt + 1'b1;
  end
  assign phase = frame_cnt[FLASH_LOG-1];
endmodule

// File: rtl/cc_dot_shaper.sv
module cc_dot_shaper #(
  parameter int CELL_LINES = 8,
  parameter int LINE_W     = 3
) (
  input  logic                               active,
  input  logic                               blank_cell,
  input  cc_caption_pkg::cc_attr_t           attr,
  input  logic [LINE_W-1:0]                  scan_row,
  input  logic [cc_caption_pkg::CELL_W-1:0]  font_bits,
  input  logic [cc_caption_pkg::DOT_W-1:0]   dot,
  input  logic                               phase,
  output logic                               ul_hit,
  output logic                               flash_hidden,
  output logic                               fg
);
  import cc_caption_pkg::*;
  localparam logic [LINE_W-1:0] UPPER_END = LINE_W'(CELL_LINES / 2);
  localparam logic [LINE_W-1:0] BOTTOM    = LINE_W'(CELL_LINES - 1);

  logic [CELL_W-1:0] line_bits;
  logic              glyph_on;

  always_comb begin
    line_bits    = slant(font_bits, attr.italic && (scan_row < UPPER_END));
    glyph_on     = pick_dot(line_bits, dot);
    ul_hit       = attr.uline && (scan_row == BOTTOM);
    flash_hidden = attr.flash && !phase;
    fg           = active && !blank_cell && !flash_hidden && (glyph_on || ul_hit);
  end
endmodule

// File: rtl/cc_caption_row.sv
module cc_caption_row #(
  parameter int ROWS       = 15,
  parameter int COLS       = 32,
  parameter int CELL_LINES = 8,
  parameter int FLASH_LOG  = 5,
  localparam int ROW_W     = $clog2(ROWS),
  localparam int COL_W     = $clog2(COLS + 1),
  localparam int LINE_W    = $clog2(CELL_LINES),
  localparam int ADDR_W    = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync,
  input  logic              line_start,
  input  logic [ROW_W-1:0]  row_sel,
  input  logic [LINE_W-1:0] scan_row,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_data,
  output logic [6:0]        font_idx,
  output logic [LINE_W-1:0] font_line,
  input  logic [7:0]        font_bits,
  output logic              r,
  output logic              g,
  output logic              b,
  output logic              bl
);
  import cc_caption_pkg::*;

  logic                 busy, cell_end, row_last;
  logic [COL_W-1:0]     col;
  logic [DOT_W-1:0]     dot;
  cc_attr_t             attr;
  logic [FLASH_LOG-1:0] frame_cnt;
  logic                 flash_phase;
  logic                 lead_cell, ctrl_cell, attr_load;
  logic                 ul_hit, flash_hidden, fg;

  cc_cell_timer #(.COLS(COLS), .COL_W(COL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .busy(busy), .col(col), .dot(dot), .cell_end(cell_end), .row_last(row_last)
  );

  assign mem_addr  = {row_sel, col};
  assign lead_cell = (col == '0);
  assign ctrl_cell = !lead_cell && is_ctrl(mem_data);
  assign attr_load = cell_end && (lead_cell || ctrl_cell);
  assign font_idx  = mem_data[GIDX_W-1:0];
  assign font_line = scan_row;

  cc_attr_state u_attr (
    .clk(clk), .rst_n(rst_n), .load(attr_load), .code(mem_data), .attr(attr)
  );

  cc_flash_timer #(.FLASH_LOG(FLASH_LOG)) u_flash (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .frame_cnt(frame_cnt), .phase(flash_phase)
  );

  cc_dot_shaper #(.CELL_LINES(CELL_LINES), .LINE_W(LINE_W)) u_shape (
    .active(busy), .blank_cell(lead_cell || ctrl_cell), .attr(attr),
    .scan_row(scan_row), .font_bits(font_bits), .dot(dot), .phase(flash_phase),
    .ul_hit(ul_hit), .flash_hidden(flash_hidden), .fg(fg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {r, g, b, bl} <= '0;
    end else begin
      r  <= fg && attr.color[2];
      g  <= fg && attr.color[1];
      b  <= fg && attr.color[0];
      bl <= fg;
    end
  end
endmodule

// File: rtl/cc_caption_row_chk.sv
module cc_caption_row_chk #(
  parameter int COLS      = 32,
  parameter int COL_W     = 6,
  parameter int FLASH_LOG = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 vsync,
  input logic                 line_start,
  input logic                 busy,
  input logic                 lead_cell,
  input logic                 ctrl_cell,
  input logic                 row_last,
  input logic                 attr_flash,
  input logic                 flash_phase,
  input logic [FLASH_LOG-1:0] frame_cnt,
  input logic [COL_W-1:0]     col,
  input logic                 r,
  input logic                 g,
  input logic                 b,
  input logic                 bl
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS);

  p_idle_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (!bl && !r && !g && !b));
  p_stop_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (row_last && !line_start) |=> !busy);
  p_col_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (col <= LAST_COL));
  p_lead_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lead_cell) |=> !bl);
  p_ctrl_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_cell) |=> !bl);
  p_flash_hide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && attr_flash && !flash_phase) |=> !bl);
  p_frame_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |=> (frame_cnt == $past(frame_cnt) + 1'b1));
  p_dark_rgb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bl |-> !(r || g || b));
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (busy && col == '0));
endmodule

bind cc_caption_row cc_caption_row_chk #(.COLS(COLS), .COL_W(COL_W), .FLASH_LOG(FLASH_LOG)) u_chk (
  .clk(clk), .rst_n(rst_n), .vsync(vsync), .line_start(line_start), .busy(busy),
  .lead_cell(lead_cell), .ctrl_cell(ctrl_cell), .row_last(row_last),
  .attr_flash(attr.flash), .flash_phase(flash_phase), .frame_cnt(frame_cnt),
  .col(col), .r(r), .g(g), .b(b), .bl(bl)
);

// File: tb/sim_cc_caption_row.sv
module sim_cc_caption_row;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vsync = 1'b0;
  logic       line_start = 1'b0;
  logic [3:0] row_sel = '0;
  logic [2:0] scan_row = '0;
  logic [9:0] mem_addr;
  logic [7:0] mem_data;
  logic [6:0] font_idx;
  logic [2:0] font_line;
  logic [7:0] font_bits;
  logic       r, g, b, bl;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [0:1023];
  bit restart_mode = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cc_caption_row u0 (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .line_start(line_start),
    .row_sel(row_sel), .scan_row(scan_row), .mem_addr(mem_addr), .mem_data(mem_data),
    .font_idx(font_idx), .font_line(font_line), .font_bits(font_bits),
    .r(r), .g(g), .b(b), .bl(bl)
  );

  function automatic int font_of(int idx, int line);
    return ((idx * 29 + line * 53 + 17) ^ (idx << 3)) & 255;
  endfunction

  assign mem_data  = mem[mem_addr];
  assign font_bits = 8'(font_of(int'(font_idx), int'(font_line)));

  // behavioural reference
  bit    m_on = 0;
  int    m_n = 0, m_color = 0, frames = 0;
  bit    m_ital = 0, m_ul = 0, m_fl = 0, m_seen = 0;
  int    e_rgb = 0;
  bit    e_bl = 0;
  string tag = "R1";

  always @(posedge clk) begin
    int col, dotn, code, line;
    bit fg;
    if (!rst_n) begin
      m_on = 0; m_n = 0; m_color = 0; m_ital = 0; m_ul = 0; m_fl = 0;
      m_seen = 0; frames = 0; e_rgb = 0; e_bl = 0; tag = "R1";
    end else begin
      e_rgb = 0; e_bl = 0; tag = "R2";
      if (m_on) begin
        col = m_n / 8; dotn = m_n % 8;
        code = int'(mem[int'(row_sel) * 64 + col]);
        fg = 0;
        if (col == 0) tag = "R3";
        else if (code >= 128) tag = "R5";
        else begin
          line = font_of(code & 127, int'(scan_row));
          tag = m_seen ? "R4" : "R3";
          if (m_ital && scan_row < 4) begin line = line >> 1; tag = "R6"; end
          fg = ((line >> (7 - dotn)) & 1) != 0;
          if (m_ul && scan_row == 7) begin fg = 1; tag = "R7"; end
          if (m_fl && ((frames >> 4) & 1) == 0) begin fg = 0; tag = "R8"; end
          if (m_fl) tag = "R8";
        end
        e_bl = fg;
        e_rgb = fg ? m_color : 0;
        if (dotn == 7 && (col == 0 || code >= 128)) begin
          m_color = code & 7; m_ital = code[3]; m_ul = code[4]; m_fl = code[5];
          m_seen = (col != 0);
        end
        if (dotn == 7 && col == 32) m_on = 0;
        else m_n = m_n + 1;
      end
      if (line_start) begin m_on = 1; m_n = 0; end
      if (vsync) frames = (frames + 1) % 32;
      if (restart_mode) tag = "R10";
    end
  end

  always @(negedge clk) begin
    int col, code;
    if (!done) begin
      checks++;
      if ({r, g, b} != 3'(e_rgb) || bl != e_bl) begin
        errors++;
        $display("FAIL %s: rgb=%0d bl=%0d expected rgb=%0d bl=%0d at %0t",
                 tag, {r, g, b}, bl, e_rgb, e_bl, $time);
      end
      checks++;
      if (!bl && (r || g || b)) begin
        errors++;
        $display("FAIL R9: rgb=%0d with bl=0, expected rgb=0", {r, g, b});
      end
      if (m_on) begin
        col = m_n / 8;
        code = int'(mem[int'(row_sel) * 64 + col]);
        if (col != 0 && code < 128) begin
          checks++;
          if (int'(font_idx) != code || font_line != scan_row) begin
            errors++;
            $display("FAIL R11: font_idx=%0d font_line=%0d expected %0d %0d",
                     font_idx, font_line, code, scan_row);
          end
        end
      end
    end
  end

  task automatic scan(input int row, input int sl);
    @(negedge clk);
    row_sel = 4'(row); scan_row = 3'(sl); line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    repeat (270) @(negedge clk);
  endtask

  task automatic fields(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); vsync = 1'b1;
      @(negedge clk); vsync = 1'b0;
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 7) & 127);
    mem[3*64] = 8'h05;                          // R3 seed: colour 5
    for (int c = 1; c <= 32; c++) mem[3*64 + c] = 8'(32 + c * 3);
    mem[3*64 + 6]  = 8'h8B;                     // R5 italics, colour 3
    mem[3*64 + 12] = 8'h96;                     // underline, colour 6
    mem[3*64 + 18] = 8'hA7;                     // flash, colour 7
    mem[3*64 + 25] = 8'h82;                     // plain colour 2
    mem[5*64] = 8'h3C;                          // flash+ul+italic, colour 4
    for (int c = 1; c <= 32; c++) mem[5*64 + c] = 8'((c * 5) & 127);
    mem[5*64 + 31] = 8'h7F;                     // R11 last glyph index
    mem[5*64 + 32] = 8'h00;
    mem[5*64 + 20] = 8'h81;                     // drop effects mid-row
    mem[0] = 8'h00;

    repeat (4) @(negedge clk);
    checks++;                                   // R1 during reset
    if ({r, g, b, bl} != 4'b0) begin
      errors++; $display("FAIL R1: outputs=%b expected 0000", {r, g, b, bl});
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;                                   // R1 after release
    if ({r, g, b, bl} != 4'b0) begin
      errors++; $display("FAIL R1: outputs=%b expected 0000", {r, g, b, bl});
    end

    scan(3, 0); scan(3, 7); scan(3, 5);
    scan(5, 0); scan(5, 7); scan(0, 2);
    fields(16);                                 // R8 phase goes high
    scan(3, 7); scan(5, 0); scan(5, 7); scan(5, 4);
    // R10 restart in the middle of a row
    @(negedge clk);
    row_sel = 4'd3; scan_row = 3'd1; line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    repeat (140) @(negedge clk);
    restart_mode = 1;
    line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    repeat (270) @(negedge clk);
    restart_mode = 0;
    fields(16);                                 // R8 phase back to low
    scan(5, 3); scan(3, 6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1;
    errors++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule